// File: doc/BRIEF.md
# Register-Controlled Pin Port with Burst Write Window

This block is a 24-pin general purpose I/O port that sits behind a simple 32-bit register bus (word address, write strobe, write data, combinational read data). Software decides per pin whether it is an output by setting a bit in an enable register. A data register supplies the level for every driven pin, and the sampled pin levels come back through a read-only input register of their own.

The data register is reachable through a window of 64 consecutive word addresses. Every address in that window aliases the same register. A bus master can therefore stream a burst of up to 64 words at rising addresses, and each word lands on the pins in turn without a new address for each word. Only the low 24 bits of each word reach the pins. A mode bit moves the port out of normal mode, and in that case no pin is driven, whatever the enable register holds.

Word addresses (default parameters): 0..63 data window, 64 enable register, 65 input register (read-only), 66 mode register (bit 0: 0 = normal, 1 = alternate). All other addresses are unmapped.

Top module: `gpio_burst_port`

## Requirements
- R1: After reset, pin_oe is all zero, pin_out is zero, the mode is normal, and reads of addresses 0, 64 and 66 return 0.
- R2: A write to address 64 stores its low 24 bits as the enable register. In normal mode pin_oe equals that register from the clock after the write, and a read of address 64 returns it zero-extended.
- R3: pin_out carries the data register on every pin, so every pin whose enable bit is set drives the written value.
- R4: A write to any of the word addresses 0 through 63 updates the data register, and pin_out shows the new value one clock after the write strobe is sampled.
- R5: Writes on consecutive clocks to different window addresses each produce their own pin value, one per clock, in order.
- R6: Bits 31..24 of a window write are discarded: only bits 23..0 reach pin_out.
- R7: A read of any address in 0..63 returns the last data written, with bits 31..24 equal to 0.
- R8: A read of address 65 returns the pin_in levels, zero-extended. A change on pin_in becomes visible there after three rising clock edges (two synchronizer stages and the input register). Writes to address 65 have no effect.
- R9: For pins left as inputs, the data register does not affect what address 65 reads or what pin_oe shows.
- R10: Writing 1 to bit 0 of address 66 forces pin_oe to all zero, whatever the enable register holds. Writing 0 brings back the stored enables unchanged.
- R11: Writes to unmapped addresses (67 and above) change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Word address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 24 | Pin levels from the pads |
| pin_out | output | 24 | Pin levels to the pads |
| pin_oe | output | 24 | Per-pin output enable to the pads |

## Verification
The hardest case to reach is a burst of back-to-back window writes in which every strobe hits a different aliased address and each pin value lasts a single clock. The stimulus drives one write per clock on the falling edge, at addresses 3, 40 and 63, and checks pin_out between strobes. The bench also sets enables, moves to the alternate mode and back, and then checks that the enables come back intact. The input path is driven while the data register holds a conflicting value, so the three-edge latency and the independence from the data register are seen in the same test.

// File: rtl/gpio_burst_pkg.sv
package gpio_burst_pkg;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_WIN,
      SEL_OE,
      SEL_MISC
   } sel_kind_e;

   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_ALT    = 1'b1
   } port_mode_e;

   function automatic logic win_hit(input logic [31:0] addr,
                                    input int unsigned base,
                                    input int unsigned words);
      return (addr >= base) && (addr < base + words);
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_burst_pkg::*;
#(
   parameter int unsigned PIN_W     = 24,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned WIN_BASE  = 0,
   parameter int unsigned WIN_WORDS = 64,
   parameter int unsigned OE_ADDR   = 64,
   parameter int unsigned IN_ADDR   = 65,
   parameter int unsigned MODE_ADDR = 66
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  in_sync,
   output logic [PIN_W-1:0]  data_q,
   output logic [PIN_W-1:0]  oe_q,
   output port_mode_e        mode_q
);

   localparam int unsigned PAD_W = BUS_W - PIN_W;

   logic [31:0]      addr_ext;
   sel_kind_e        sel;
   logic [PIN_W-1:0] in_q;
   logic [PIN_W-1:0] wr_pins;

   assign addr_ext = 32'(bus_addr);
   assign wr_pins  = bus_wdata[PIN_W-1:0];

   always_comb begin
      if (win_hit(addr_ext, WIN_BASE, WIN_WORDS))                        sel = SEL_WIN;
      else if (addr_ext == OE_ADDR)                                       sel = SEL_OE;
      else if ((addr_ext == IN_ADDR) || (addr_ext == MODE_ADDR))          sel = SEL_MISC;
      else                                                                 sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         oe_q   <= '0;
         mode_q <= MODE_NORMAL;
         in_q   <= '0;
      end else begin
         in_q <= in_sync;
         if (bus_wr) begin
            if (sel == SEL_WIN) data_q <= wr_pins;
            if (sel == SEL_OE)  oe_q   <= wr_pins;
            if ((sel == SEL_MISC) && (addr_ext == MODE_ADDR))
               mode_q <= port_mode_e'(bus_wdata[0]);
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_WIN:  bus_rdata = {{PAD_W{1'b0}}, data_q};
         SEL_OE:   bus_rdata = {{PAD_W{1'b0}}, oe_q};
         SEL_MISC: begin
            if (addr_ext == IN_ADDR) bus_rdata = {{PAD_W{1'b0}}, in_q};
            else                     bus_rdata = BUS_W'(mode_q);
         end
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_burst_pkg::*;
#(
   parameter int unsigned PIN_W = 24
) (
   input  logic [PIN_W-1:0] data_q,
   input  logic [PIN_W-1:0] oe_q,
   input  port_mode_e       mode_q,
   output logic [PIN_W-1:0] pin_out,
   output logic [PIN_W-1:0] pin_oe
);

   logic drive_ok;
   assign drive_ok = (mode_q == MODE_NORMAL);

   generate
      genvar p;
      for (p = 0; p < PIN_W; p++) begin : g_pin
         assign pin_out[p] = data_q[p];
         assign pin_oe[p]  = oe_q[p] & drive_ok;
      end
   endgenerate

endmodule

// File: rtl/gpio_burst_port.sv
module gpio_burst_port
   import gpio_burst_pkg::*;
#(
   parameter int unsigned PIN_W       = 24,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned WIN_BASE    = 0,
   parameter int unsigned WIN_WORDS   = 64,
   parameter int unsigned OE_ADDR     = 64,
   parameter int unsigned IN_ADDR     = 65,
   parameter int unsigned MODE_ADDR   = 66,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   localparam int unsigned WIN_END = WIN_BASE + WIN_WORDS;

   generate
      if (PIN_W >= BUS_W) begin : g_bad_width
         $error("PIN_W must be narrower than BUS_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WIN_END > (1 << ADDR_W)) begin : g_bad_win
         $error("window does not fit the address space");
      end
      if ((OE_ADDR >= WIN_BASE && OE_ADDR < WIN_END) ||
          (IN_ADDR >= WIN_BASE && IN_ADDR < WIN_END) ||
          (MODE_ADDR >= WIN_BASE && MODE_ADDR < WIN_END)) begin : g_bad_map
         $error("control register overlaps the data window");
      end
   endgenerate

   logic [PIN_W-1:0] in_sync;
   logic [PIN_W-1:0] data_q;
   logic [PIN_W-1:0] oe_q;
   port_mode_e       mode_q;
   logic             mode_alt;

   assign mode_alt = (mode_q == MODE_ALT);

   gpio_in_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (in_sync)
   );

   gpio_regfile #(
      .PIN_W     (PIN_W),
      .BUS_W     (BUS_W),
      .ADDR_W    (ADDR_W),
      .WIN_BASE  (WIN_BASE),
      .WIN_WORDS (WIN_WORDS),
      .OE_ADDR   (OE_ADDR),
      .IN_ADDR   (IN_ADDR),
      .MODE_ADDR (MODE_ADDR)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .in_sync   (in_sync),
      .data_q    (data_q),
      .oe_q      (oe_q),
      .mode_q    (mode_q)
   );

   gpio_pad_ctrl #(
      .PIN_W (PIN_W)
   ) pads_i (
      .data_q  (data_q),
      .oe_q    (oe_q),
      .mode_q  (mode_q),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

endmodule

// File: rtl/gpio_burst_port_chk.sv
module gpio_burst_port_chk #(
   parameter int unsigned PIN_W     = 24,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned WIN_BASE  = 0,
   parameter int unsigned WIN_WORDS = 64,
   parameter int unsigned OE_ADDR   = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe,
   input logic              mode_alt
);

   logic in_win;
   logic oe_hit;
   assign in_win = (32'(bus_addr) >= WIN_BASE) && (32'(bus_addr) < WIN_BASE + WIN_WORDS);
   assign oe_hit = (32'(bus_addr) == OE_ADDR);

   // R4 R6
   win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && in_win) |=> (pin_out == $past(bus_wdata[PIN_W-1:0])));

   // R5
   pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && in_win) |=> $stable(pin_out));

   // R7
   win_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> ((bus_rdata >> PIN_W) == '0));

   // R10
   alt_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_alt |-> (pin_oe == '0));

   // R2
   oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && oe_hit) |=> (mode_alt || (pin_oe == $past(bus_wdata[PIN_W-1:0]))));

endmodule

bind gpio_burst_port gpio_burst_port_chk #(
   .PIN_W     (PIN_W),
   .BUS_W     (BUS_W),
   .ADDR_W    (ADDR_W),
   .WIN_BASE  (WIN_BASE),
   .WIN_WORDS (WIN_WORDS),
   .OE_ADDR   (OE_ADDR)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .mode_alt  (mode_alt)
);

// File: tb/gpio_burst_port_tb.sv
module gpio_burst_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out;
   logic [23:0] pin_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   gpio_burst_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1 oe", 32'(pin_oe), 32'h0);
      check("R1 out", 32'(pin_out), 32'h0);
      rd(8'd0, v);  check("R1 data read", v, 32'h0);
      rd(8'd64, v); check("R1 oe read", v, 32'h0);
      rd(8'd66, v); check("R1 mode read", v, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] v;
      wr(8'd64, 32'hAB0F_F00F);
      check("R2 pin_oe", 32'(pin_oe), 32'h000F_F00F);
      rd(8'd64, v); check("R2 oe read", v, 32'h000F_F00F);
   endtask

   task automatic t_window;
      logic [31:0] v;
      wr(8'd0, 32'h0012_3456);
      check("R4 addr0", 32'(pin_out), 32'h0012_3456);
      check("R3 driven pins", 32'(pin_out & pin_oe), 32'h0002_3006);
      wr(8'd63, 32'hFF65_4321);
      check("R6 top bits dropped", 32'(pin_out), 32'h0065_4321);
      rd(8'd17, v); check("R7 alias read 17", v, 32'h0065_4321);
      rd(8'd63, v); check("R7 alias read 63", v, 32'h0065_4321);
   endtask

   task automatic t_burst;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'd3;  bus_wdata = 32'h11AA_AAAA;
      @(negedge clk);
      check("R5 word0", 32'(pin_out), 32'h00AA_AAAA);
      bus_addr = 8'd40; bus_wdata = 32'h2255_5555;
      @(negedge clk);
      check("R5 word1", 32'(pin_out), 32'h0055_5555);
      bus_addr = 8'd63; bus_wdata = 32'h33C3_C3C3;
      @(negedge clk);
      check("R5 word2", 32'(pin_out), 32'h00C3_C3C3);
      bus_wr = 1'b0;
      @(negedge clk);
      check("R5 hold", 32'(pin_out), 32'h00C3_C3C3);
   endtask

   task automatic t_inputs;
      logic [31:0] v;
      wr(8'd0, 32'h00FF_FFFF);
      wr(8'd64, 32'h0);
      @(negedge clk);
      pin_in = 24'h5A_0C3E;
      @(negedge clk);
      @(negedge clk);
      rd(8'd65, v); check("R8 not before 3 edges", v, 32'h0);
      @(negedge clk);
      rd(8'd65, v); check("R8 after 3 edges", v, 32'h005A_0C3E);
      check("R9 data no effect on read", v, 32'h005A_0C3E);
      check("R9 no drive", 32'(pin_oe), 32'h0);
      wr(8'd65, 32'h0);
      rd(8'd65, v); check("R8 write ignored", v, 32'h005A_0C3E);
   endtask

   task automatic t_mode;
      logic [31:0] v;
      wr(8'd64, 32'h0080_0101);
      wr(8'd66, 32'h1);
      check("R10 alt quiet", 32'(pin_oe), 32'h0);
      rd(8'd66, v); check("R10 mode read", v, 32'h1);
      wr(8'd66, 32'h0);
      check("R10 restore", 32'(pin_oe), 32'h0080_0101);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(8'd67, 32'hFFFF_FFFF);
      wr(8'd200, 32'h0000_0001);
      check("R11 pins", 32'(pin_out), 32'h00FF_FFFF);
      check("R11 oe", 32'(pin_oe), 32'h0080_0101);
      rd(8'd66, v);  check("R11 mode", v, 32'h0);
      rd(8'd67, v);  check("R11 read 67", v, 32'h0);
      rd(8'd255, v); check("R11 read 255", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_window();
      t_burst();
      t_inputs();
      t_mode();
      t_unmapped();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule